// File: doc/BRIEF.md
# Single-Lane Serial Link Transport Framer

This block sits in front of the 8b/10b encoder of one serial converter lane. It accepts one 14-bit converter sample per two-octet frame and emits one octet per clock, with a flag that marks the octet as a control character. Two spare bits in each frame can carry range and validity flags. A tail select input chooses which flags they carry.

A local multiframe phase counter counts octets within a multiframe. A SYSREF pulse reloads it with a programmable phase. While the receiver holds SYNC low, the block sends comma characters. Once SYNC is released, the block waits for the next multiframe boundary and then sends a four-multiframe lane alignment sequence. That sequence carries the link parameters and a checksum. User data follows it.

User data can pass through an optional self-synchronous scrambler. Three test modes replace the last octet of each frame. All configuration arrives on static input ports.

Top module: `jtx_lane_framer`

## Requirements
- R1: The octet presented after a clock edge is computed from the inputs and state sampled at that edge. In the user-data phase with scrambling off, the octet in an even counter slot is sample bits 13..6 (bit 13 in octet bit 7). The octet in an odd slot is sample bits 5..0 in octet bits 7..2, followed by the two tail bits. The tail bits and sample LSBs are those captured in the preceding even slot. ctrl_o is 0 for every user-data octet.
- R2: The first tail bit sits in octet bit 1 and the second in bit 0. By tail_sel_i they are: 0 = {over|under, valid}; 1 = {over, under}; 2 = {over|under, 0}; 3 = {0, valid}; 4 = {0, 0}; 5 = {under, over}; 6 = {valid, over|under}; 7 = {0, 0}. With tail_en_i low both bits are 0.
- R3: With offset_bin_i high, sample bit 13 is inverted before packing. Otherwise the sample is sent as given.
- R4: With scr_en_i high, each user-data octet is scrambled MSB first: out = in XOR s[t-14] XOR s[t-15], where s is the sequence of scrambled output bits. The history starts at zero after reset and advances only on scrambled user-data octets. Control characters and alignment octets are never scrambled.
- R5: cfg_err_o is high when K = k_cfg_i + 1 is odd (two-octet frames times K is then not a multiple of four) or when K < 9 (too short for the parameter block). Otherwise it is low.
- R6: The phase counter runs 0..2K-1 and returns to 0 after 2K-1. When sysref_i is high at an edge, the counter loads lmfc_offset_i. A value above 2K-1 returns to 0 at the following edge. Slot 0 is a multiframe boundary.
- R7: Whenever sync_n_i is low at an edge, the next octet is K28.5 (0xBC, ctrl_o=1), and the block returns to the synchronisation state. Reset yields the same output.
- R8: After sync_n_i rises, K28.5 continues up to and including the counter slot 2K-1. The alignment sequence starts in the following slot.
- R9: The alignment sequence lasts four multiframes. Slot 0 is K28.0 (0x1C, ctrl) and slot 2K-1 is K28.3 (0x7C, ctrl). Other slots not covered by R10 carry the slot number as a data octet. User data starts at the next boundary.
- R10: In the second multiframe, slot 1 is K28.4 (0x9C, ctrl). Slots 2..15 carry these data octets in order: device id; {0000, bank id}; {000, lane id}; {scramble enable, 0000000}; 1; {000, k_cfg}; 0; 13; 15; 0; 0; 0; 0; and a checksum equal to the modulo-256 sum of the thirteen before it.
- R11: test_mode_i replaces the odd-slot octet before scrambling. 1 sends the unmodified odd-slot octet of the previous frame; 2 sends 0xFC; 3 sends 0x7C. All three have ctrl_o=0. 0 is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 14 | Converter sample, read in even slots |
| over_i | input | 1 | Over-range flag |
| under_i | input | 1 | Under-range flag |
| valid_i | input | 1 | Sample valid flag |
| tail_en_i | input | 1 | Enables flag insertion in the tail bits |
| tail_sel_i | input | 3 | Tail bit meaning select |
| offset_bin_i | input | 1 | Offset binary output format |
| scr_en_i | input | 1 | Scrambler enable |
| test_mode_i | input | 2 | Last-octet test mode |
| k_cfg_i | input | 5 | Frames per multiframe minus one |
| lmfc_offset_i | input | 5 | Phase loaded on SYSREF |
| sysref_i | input | 1 | Phase reference pulse |
| sync_n_i | input | 1 | Receiver sync request, active low |
| dev_id_i | input | 8 | Device id for the parameter block |
| bank_id_i | input | 4 | Bank id for the parameter block |
| lane_id_i | input | 5 | Lane id for the parameter block |
| octet_o | output | 8 | Outgoing octet |
| ctrl_o | output | 1 | Octet is a control character |
| cfg_err_o | output | 1 | Illegal frames-per-multiframe setting |

## Verification
The hardest conditions to reach from the ports are the second alignment multiframe and the phase-reload corner cases. The parameter octets only appear after a full sync release, a wait for a boundary, and one complete multiframe. They also shift whenever SYSREF moves the phase. The stimulus therefore drops sync in the middle of user data and releases it again. It also resets into the shortest legal multiframe, pulses SYSREF with an out-of-range offset and then with an offset equal to the final slot, and only then releases sync. A per-cycle reference model tracks every octet, including scrambled data, the repeat mode, and the parameter checksum.

// File: rtl/jtx_pkg.sv
package jtx_pkg;
  typedef enum logic [1:0] {
    ST_SYNC = 2'd0,
    ST_ILAS = 2'd1,
    ST_DATA = 2'd2
  } link_st_e;

  localparam int SMP_W = 14;
  localparam logic [7:0] CH_K285 = 8'hBC;
  localparam logic [7:0] CH_K280 = 8'h1C;
  localparam logic [7:0] CH_K283 = 8'h7C;
  localparam logic [7:0] CH_K284 = 8'h9C;
  localparam logic [7:0] CH_D287 = 8'hFC;
  localparam logic [7:0] CH_D283 = 8'h7C;

  localparam logic [1:0] TM_NORMAL = 2'd0;
  localparam logic [1:0] TM_REPEAT = 2'd1;
  localparam logic [1:0] TM_D287   = 2'd2;
endpackage

// File: rtl/jtx_lmfc.sv
module jtx_lmfc #(
  parameter int K_W   = 5,
  parameter int OFF_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [K_W-1:0]   k_m1,
  input  logic [OFF_W-1:0] offset,
  input  logic             sysref,
  output logic [K_W:0]     cnt,
  output logic             mf_end
);
  localparam int C_W = K_W + 1;

  logic [C_W-1:0] last;
  logic [C_W-1:0] cnt_d;

  // 2K-1 = 2*(k_m1+1)-1
  assign last   = {k_m1, 1'b1};
  assign mf_end = (cnt >= last);

  always_comb begin
    if (sysref)      cnt_d = C_W'(offset);
    else if (mf_end) cnt_d = '0;
    else             cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/jtx_packer.sv
module jtx_packer
  import jtx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_odd,
  input  logic [SMP_W-1:0] sample,
  input  logic             over,
  input  logic             under,
  input  logic             valid,
  input  logic             tail_en,
  input  logic [2:0]       tail_sel,
  input  logic             offset_bin,
  input  logic [1:0]       test_mode,
  output logic [7:0]       frame_octet
);
  localparam int LSB_W = SMP_W - 8;

  logic [SMP_W-1:0] fmt;
  logic [1:0]       tail;
  logic             either;
  logic [7:0]       nat_lo;
  logic [7:0]       lo_hold, lo_hold_d;
  logic [7:0]       lo_prev, lo_prev_d;

  assign fmt    = {sample[SMP_W-1] ^ offset_bin, sample[SMP_W-2:0]};
  assign either = over | under;

  always_comb begin
    case (tail_sel)
      3'd0:    tail = {either, valid};
      3'd1:    tail = {over, under};
      3'd2:    tail = {either, 1'b0};
      3'd3:    tail = {1'b0, valid};
      3'd5:    tail = {under, over};
      3'd6:    tail = {valid, either};
      default: tail = 2'b00;
    endcase
    if (!tail_en) tail = 2'b00;
  end

  assign nat_lo = {fmt[LSB_W-1:0], tail};

  always_comb begin
    lo_hold_d = lo_hold;
    lo_prev_d = lo_prev;
    if (!slot_odd) lo_hold_d = nat_lo;
    else           lo_prev_d = lo_hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_hold <= '0;
      lo_prev <= '0;
    end else begin
      lo_hold <= lo_hold_d;
      lo_prev <= lo_prev_d;
    end
  end

  always_comb begin
    if (!slot_odd) begin
      frame_octet = fmt[SMP_W-1:LSB_W];
    end else begin
      case (test_mode)
        TM_NORMAL: frame_octet = lo_hold;
        TM_REPEAT: frame_octet = lo_prev;
        TM_D287:   frame_octet = CH_D287;
        default:   frame_octet = CH_D283;
      endcase
    end
  end
endmodule

// File: rtl/jtx_scrambler.sv
module jtx_scrambler (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic [7:0] din,
  output logic [7:0] dout
);
  logic [14:0] hist, hist_d;

  // hist[0] is the most recent scrambled bit
  always_comb begin
    hist_d = hist;
    dout   = '0;
    for (int b = 7; b >= 0; b--) begin
      dout[b] = din[b] ^ hist_d[13] ^ hist_d[14];
      hist_d  = {hist_d[13:0], dout[b]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hist <= '0;
    else if (adv) hist <= hist_d;
  end
endmodule

// File: rtl/jtx_lane_framer.sv
module jtx_lane_framer
  import jtx_pkg::*;
#(
  parameter int K_W   = 5,
  parameter int OFF_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [13:0]      sample_i,
  input  logic             over_i,
  input  logic             under_i,
  input  logic             valid_i,
  input  logic             tail_en_i,
  input  logic [2:0]       tail_sel_i,
  input  logic             offset_bin_i,
  input  logic             scr_en_i,
  input  logic [1:0]       test_mode_i,
  input  logic [K_W-1:0]   k_cfg_i,
  input  logic [OFF_W-1:0] lmfc_offset_i,
  input  logic             sysref_i,
  input  logic             sync_n_i,
  input  logic [7:0]       dev_id_i,
  input  logic [3:0]       bank_id_i,
  input  logic [4:0]       lane_id_i,
  output logic [7:0]       octet_o,
  output logic             ctrl_o,
  output logic             cfg_err_o
);
  localparam int C_W       = K_W + 1;
  localparam int PRM_N     = 14;
  localparam int PRM_FIRST = 2;
  localparam int PRM_END   = PRM_FIRST + PRM_N - 1;
  localparam int MIN_KM1   = (PRM_END + 1) / 2;
  localparam int ILAS_MF   = 4;
  localparam int MF_W      = $clog2(ILAS_MF);

  link_st_e        st_q, st_d;
  logic [MF_W-1:0] mf_q, mf_d;
  logic [C_W-1:0]  lmfc_cnt;
  logic            mf_end;
  logic [7:0]      frame_octet;
  logic [7:0]      scr_octet;
  logic            scr_adv;
  logic [7:0]      oct_d;
  logic            ctrl_d;
  logic [7:0]      prm [PRM_N];
  logic [7:0]      prm_sum;
  logic [3:0]      prm_idx;

  jtx_lmfc #(.K_W(K_W), .OFF_W(OFF_W)) i_lmfc (
    .clk    (clk),
    .rst_n  (rst_n),
    .k_m1   (k_cfg_i),
    .offset (lmfc_offset_i),
    .sysref (sysref_i),
    .cnt    (lmfc_cnt),
    .mf_end (mf_end)
  );

  jtx_packer i_packer (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_odd    (lmfc_cnt[0]),
    .sample      (sample_i),
    .over        (over_i),
    .under       (under_i),
    .valid       (valid_i),
    .tail_en     (tail_en_i),
    .tail_sel    (tail_sel_i),
    .offset_bin  (offset_bin_i),
    .test_mode   (test_mode_i),
    .frame_octet (frame_octet)
  );

  assign scr_adv = (st_q == ST_DATA) && sync_n_i && scr_en_i;

  jtx_scrambler i_scr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (scr_adv),
    .din   (frame_octet),
    .dout  (scr_octet)
  );

  // F=2, so F*K is a multiple of four exactly when K is even (k_cfg odd)
  assign cfg_err_o = ~k_cfg_i[0] | (k_cfg_i < K_W'(MIN_KM1));

  // parameter block of the second alignment multiframe
  always_comb begin
    prm[0]  = dev_id_i;
    prm[1]  = {4'h0, bank_id_i};
    prm[2]  = {3'b000, lane_id_i};
    prm[3]  = {scr_en_i, 7'd0};
    prm[4]  = 8'd1;
    prm[5]  = 8'(k_cfg_i);
    prm[6]  = 8'd0;
    prm[7]  = 8'd13;
    prm[8]  = 8'd15;
    prm[9]  = 8'd0;
    prm[10] = 8'd0;
    prm[11] = 8'd0;
    prm[12] = 8'd0;
    prm_sum = '0;
    for (int i = 0; i < PRM_N - 1; i++) prm_sum = prm_sum + prm[i];
    prm[PRM_N-1] = prm_sum;
  end

  assign prm_idx = 4'(lmfc_cnt - C_W'(PRM_FIRST));

  // link state next-state logic
  always_comb begin
    st_d = st_q;
    mf_d = mf_q;
    if (!sync_n_i) begin
      st_d = ST_SYNC;
      mf_d = '0;
    end else begin
      case (st_q)
        ST_SYNC: if (mf_end) begin
          st_d = ST_ILAS;
          mf_d = '0;
        end
        ST_ILAS: if (mf_end) begin
          if (mf_q == MF_W'(ILAS_MF - 1)) st_d = ST_DATA;
          else                            mf_d = mf_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // octet selection
  always_comb begin
    oct_d  = frame_octet;
    ctrl_d = 1'b0;
    if (!sync_n_i || st_q == ST_SYNC) begin
      oct_d  = CH_K285;
      ctrl_d = 1'b1;
    end else if (st_q == ST_ILAS) begin
      ctrl_d = 1'b1;
      if (lmfc_cnt == '0) begin
        oct_d = CH_K280;
      end else if (mf_end) begin
        oct_d = CH_K283;
      end else if (mf_q == MF_W'(1) && lmfc_cnt == C_W'(1)) begin
        oct_d = CH_K284;
      end else if (mf_q == MF_W'(1) && lmfc_cnt >= C_W'(PRM_FIRST)
                   && lmfc_cnt <= C_W'(PRM_END)) begin
        oct_d  = prm[prm_idx];
        ctrl_d = 1'b0;
      end else begin
        oct_d  = 8'(lmfc_cnt);
        ctrl_d = 1'b0;
      end
    end else if (scr_en_i) begin
      oct_d = scr_octet;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_SYNC;
      mf_q    <= '0;
      octet_o <= CH_K285;
      ctrl_o  <= 1'b1;
    end else begin
      st_q    <= st_d;
      mf_q    <= mf_d;
      octet_o <= oct_d;
      ctrl_o  <= ctrl_d;
    end
  end
endmodule

// File: rtl/jtx_lane_framer_chk.sv
module jtx_lane_framer_chk #(
  parameter int K_W   = 5,
  parameter int OFF_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_n_i,
  input logic             sysref_i,
  input logic [OFF_W-1:0] lmfc_offset_i,
  input logic [K_W-1:0]   k_cfg_i,
  input logic [7:0]       octet_o,
  input logic             ctrl_o,
  input logic [1:0]       st,
  input logic [K_W:0]     cnt
);
  logic [K_W:0] last;
  assign last = {k_cfg_i, 1'b1};

  assert_sync_comma_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sync_n_i) |-> (ctrl_o && octet_o == 8'hBC));

  assert_ctrl_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o |-> (octet_o == 8'h1C || octet_o == 8'h7C || octet_o == 8'h9C || octet_o == 8'hBC));

  assert_data_plain_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == 2'd2 && $past(sync_n_i)) |-> !ctrl_o);

  assert_phase_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sysref_i) && ($past(lmfc_offset_i) <= OFF_W'($past(last))))
      |-> (cnt == (K_W+1)'($past(lmfc_offset_i))));

  assert_phase_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sysref_i) |-> (cnt <= last));

  assert_align_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == 2'd0 && st == 2'd1 && !$past(sysref_i)) |-> (cnt == '0));
endmodule

bind jtx_lane_framer jtx_lane_framer_chk #(.K_W(K_W), .OFF_W(OFF_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sync_n_i      (sync_n_i),
  .sysref_i      (sysref_i),
  .lmfc_offset_i (lmfc_offset_i),
  .k_cfg_i       (k_cfg_i),
  .octet_o       (octet_o),
  .ctrl_o        (ctrl_o),
  .st            (st_q),
  .cnt           (lmfc_cnt)
);

// File: tb/test_jtx_lane_framer.sv
module test_jtx_lane_framer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] sample_i;
  logic        over_i, under_i, valid_i, tail_en_i, offset_bin_i, scr_en_i;
  logic [2:0]  tail_sel_i;
  logic [1:0]  test_mode_i;
  logic [4:0]  k_cfg_i, lmfc_offset_i, lane_id_i;
  logic        sysref_i, sync_n_i;
  logic [7:0]  dev_id_i;
  logic [3:0]  bank_id_i;
  logic [7:0]  octet_o;
  logic        ctrl_o, cfg_err_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  jtx_lane_framer i_jtx_lane_framer (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .over_i(over_i), .under_i(under_i),
    .valid_i(valid_i), .tail_en_i(tail_en_i), .tail_sel_i(tail_sel_i),
    .offset_bin_i(offset_bin_i), .scr_en_i(scr_en_i), .test_mode_i(test_mode_i),
    .k_cfg_i(k_cfg_i), .lmfc_offset_i(lmfc_offset_i), .sysref_i(sysref_i),
    .sync_n_i(sync_n_i), .dev_id_i(dev_id_i), .bank_id_i(bank_id_i), .lane_id_i(lane_id_i),
    .octet_o(octet_o), .ctrl_o(ctrl_o), .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual ctrl/octet=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_tail(input logic [2:0] sel, input logic en,
                                          input logic ov, input logic un, input logic vl);
    logic ou;
    ou = ov | un;
    if (!en) return 2'b00;
    case (sel)
      3'd0: return {ou, vl};
      3'd1: return {ov, un};
      3'd2: return {ou, 1'b0};
      3'd3: return {1'b0, vl};
      3'd5: return {un, ov};
      3'd6: return {vl, ou};
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [7:0] scr_byte(input logic [7:0] d, input logic [14:0] h_in,
                                          output logic [14:0] h_out);
    logic [14:0] h;
    logic [7:0] o;
    h = h_in;
    for (int b = 7; b >= 0; b--) begin
      o[b] = d[b] ^ h[13] ^ h[14];
      h = {h[13:0], o[b]};
    end
    h_out = h;
    return o;
  endfunction

  // behavioural reference model
  int          m_st, m_mf, m_c;
  logic [7:0]  m_hold, m_prev;
  logic [14:0] m_scr;
  logic [7:0]  e_oct;
  logic        e_ctrl;
  string       e_tag;

  always @(posedge clk or negedge rst_n) begin : model
    int last;
    bit mfe, odd;
    logic [13:0] s;
    logic [7:0] nat1, fo, sum;
    logic [7:0] po [0:13];
    logic [14:0] h;
    if (!rst_n) begin
      m_st = 0; m_mf = 0; m_c = 0; m_hold = 0; m_prev = 0; m_scr = 0;
      e_oct = 8'hBC; e_ctrl = 1'b1; e_tag = "R7";
    end else begin
      last = 2 * int'(k_cfg_i) + 1;
      mfe  = (m_c >= last);
      odd  = (m_c % 2) == 1;
      s    = sample_i ^ {offset_bin_i, 13'd0};
      nat1 = {s[5:0], exp_tail(tail_sel_i, tail_en_i, over_i, under_i, valid_i)};
      if (!odd) fo = s[13:6];
      else case (test_mode_i)
        2'd0: fo = m_hold;
        2'd1: fo = m_prev;
        2'd2: fo = 8'hFC;
        default: fo = 8'h7C;
      endcase
      po[0] = dev_id_i; po[1] = {4'h0, bank_id_i}; po[2] = {3'b0, lane_id_i};
      po[3] = {scr_en_i, 7'd0}; po[4] = 8'd1; po[5] = {3'b0, k_cfg_i}; po[6] = 0;
      po[7] = 8'd13; po[8] = 8'd15; po[9] = 0; po[10] = 0; po[11] = 0; po[12] = 0;
      sum = 0;
      for (int i = 0; i < 13; i++) sum = sum + po[i];
      po[13] = sum;
      if (!sync_n_i || m_st == 0) begin
        e_oct = 8'hBC; e_ctrl = 1'b1; e_tag = sync_n_i ? "R8" : "R7";
      end else if (m_st == 1) begin
        e_ctrl = 1'b1; e_tag = "R9";
        if (m_c == 0) begin e_oct = 8'h1C; e_tag = "R6"; end
        else if (mfe) e_oct = 8'h7C;
        else if (m_mf == 1 && m_c == 1) begin e_oct = 8'h9C; e_tag = "R10"; end
        else if (m_mf == 1 && m_c >= 2 && m_c <= 15) begin
          e_oct = po[m_c - 2]; e_ctrl = 1'b0; e_tag = "R10";
        end else begin e_oct = 8'(m_c); e_ctrl = 1'b0; end
      end else begin
        e_ctrl = 1'b0;
        if (odd && test_mode_i != 0) e_tag = "R11";
        else if (odd) e_tag = "R2";
        else if (offset_bin_i) e_tag = "R3";
        else e_tag = "R1";
        if (scr_en_i) begin
          e_oct = scr_byte(fo, m_scr, h); m_scr = h; e_tag = "R4";
        end else e_oct = fo;
      end
      if (!odd) m_hold = nat1; else m_prev = m_hold;
      if (!sync_n_i) begin m_st = 0; m_mf = 0; end
      else if (m_st == 0 && mfe) begin m_st = 1; m_mf = 0; end
      else if (m_st == 1 && mfe) begin
        if (m_mf == 3) m_st = 2; else m_mf = m_mf + 1;
      end
      if (sysref_i) m_c = int'(lmfc_offset_i);
      else if (mfe) m_c = 0;
      else m_c = m_c + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) chk(e_tag, {ctrl_o, octet_o}, {e_ctrl, e_oct});
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample_i = 14'($urandom);
      over_i = 1'($urandom); under_i = 1'($urandom); valid_i = 1'($urandom);
    end
  endtask

  task automatic pulse_sysref(input logic [4:0] off);
    @(negedge clk);
    lmfc_offset_i = off;
    sysref_i = 1'b1;
    @(negedge clk);
    sysref_i = 1'b0;
  endtask

  task automatic restart(input logic [4:0] k);
    @(negedge clk);
    rst_n = 1'b0;
    k_cfg_i = k;
    sync_n_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_up;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_up();
  end

  initial begin : stim
    rst_n = 1'b0;
    sample_i = 0; over_i = 0; under_i = 0; valid_i = 0;
    tail_en_i = 1; tail_sel_i = 0; offset_bin_i = 0; scr_en_i = 0; test_mode_i = 0;
    k_cfg_i = 5'd15; lmfc_offset_i = 0; sysref_i = 0; sync_n_i = 0;
    dev_id_i = 8'hA5; bank_id_i = 4'h3; lane_id_i = 5'h11;
    repeat (3) @(negedge clk);
    chk("R7", {ctrl_o, octet_o}, {1'b1, 8'hBC});
    // R5: illegal frames-per-multiframe settings, checked while held in reset
    k_cfg_i = 5'd15; #1 chk("R5", {8'd0, cfg_err_o}, 9'd0);
    k_cfg_i = 5'd9;  #1 chk("R5", {8'd0, cfg_err_o}, 9'd0);
    k_cfg_i = 5'd8;  #1 chk("R5", {8'd0, cfg_err_o}, 9'd1);
    k_cfg_i = 5'd7;  #1 chk("R5", {8'd0, cfg_err_o}, 9'd1);
    k_cfg_i = 5'd10; #1 chk("R5", {8'd0, cfg_err_o}, 9'd1);
    k_cfg_i = 5'd31; #1 chk("R5", {8'd0, cfg_err_o}, 9'd0);
    restart(5'd15);
    // R6/R7/R8: comma stream, phase reload, release, alignment
    run(30);
    pulse_sysref(5'd5);
    run(20);
    sync_n_i = 1'b1;
    run(220);
    // R2: every tail select, then tail insertion off
    for (int sel = 0; sel < 8; sel++) begin
      tail_sel_i = 3'(sel);
      run(24);
    end
    tail_en_i = 0; run(20); tail_en_i = 1; tail_sel_i = 0;
    // R3: offset binary
    offset_bin_i = 1; run(20); offset_bin_i = 0;
    // R11: last-octet test modes
    for (int tm = 1; tm < 4; tm++) begin
      test_mode_i = 2'(tm);
      run(30);
    end
    test_mode_i = 0;
    // R4: scrambler, alone and with repeat mode
    scr_en_i = 1; run(200);
    test_mode_i = 1; run(40); test_mode_i = 0;
    scr_en_i = 0;
    // R7/R8: mid-stream resync
    sync_n_i = 0; run(10);
    sync_n_i = 1; run(200);
    // R6/R10: shortest legal K, out-of-range and final-slot offsets
    restart(5'd9);
    run(15);
    pulse_sysref(5'd31);
    run(7);
    pulse_sysref(5'd19);
    run(5);
    sync_n_i = 1;
    run(150);
    scr_en_i = 1; run(100);
    finish_up();
  end
endmodule